// File: doc/BRIEF.md
# DMA Write Burst Planner

This block splits a DMA buffer that is bound for host memory into a sequence of bus write bursts. For each burst it chooses the bus command. The choices are a plain memory write, a write-and-invalidate, or the block-write command of the split-transaction bus mode. It hands the choice to the bus master as a descriptor that carries the command code, the start address and the byte length. The master accepts the descriptor through a valid/ready handshake. Once the master reports the burst finished, the planner advances its address and remaining-count cursor and plans the next burst.

A job is started by a one-cycle `start_i` pulse while the block is idle. On that pulse the block latches the buffer address, the byte count, the cache line size (in 32-bit words), the invalidate enable, the bus mode and a per-burst byte cap.

In conventional PCI mode, write-and-invalidate is used for a burst that starts on a cache line boundary, provided the line size setting is usable and invalidation is enabled. Such a burst spans the greatest whole number of lines that fits both the remaining count and the cap. A misaligned head is written with a plain write up to the next boundary, and a tail shorter than one line is written with a plain write. `done_o` pulses once the last burst completes.

Top module: `dma_wr_burst_planner`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `desc_valid_o`, `busy_o` and `done_o` are all low.
- R2: A start pulse with a byte count of zero presents no descriptor. `done_o` is high for exactly one cycle, one cycle after the start pulse is sampled.
- R3: In PCI mode (`pcix_mode_i`=0), every burst uses the plain write code 4'b0111 with length min(remaining, cap) when either of these holds: `inval_en_i` is low, or the line size is not one of 1, 2, 4, 8, 16 or 32 words.
- R4: In PCI-X mode (`pcix_mode_i`=1), every burst uses the block-write code 4'b1111 with length min(remaining, cap), whatever the line size or invalidate setting.
- R5: With invalidation usable, a burst starting at a misaligned address uses code 4'b0111 with length min(bytes to the next line boundary, remaining, cap).
- R6: With invalidation usable, a burst starting on a line boundary, with at least one line remaining and a cap of at least one line, uses the write-and-invalidate code 4'b1111. Its length is the smaller of two values: the remaining count rounded down to whole lines, and the cap rounded down to whole lines.
- R7: With invalidation usable, a burst at a line boundary with fewer bytes than one line remaining uses code 4'b0111 and carries all remaining bytes (cap permitting).
- R8: No burst is longer than the cap; a cap of zero acts as one byte. When the cap is below one line, aligned bursts fall back to code 4'b0111 with length min(remaining, cap).
- R9: A presented descriptor holds its command, address and length until it is accepted, and `burst_done_i` is ignored before acceptance. After acceptance, `desc_valid_o` is low until `burst_done_i` is seen.
- R10: Each descriptor's address equals the previous address plus the previous length, and the lengths sum to the byte count. `done_o` pulses one cycle after the completion of the last burst, at which point `busy_o` is low.
- R11: A `start_i` pulse while a job is in progress is ignored: later descriptors continue from the running cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a job (sampled only when idle) |
| start_addr_i | input | ADDR_W | Buffer start address in host memory |
| byte_count_i | input | CNT_W | Number of bytes to write |
| line_words_i | input | 8 | Cache line size in 32-bit words |
| inval_en_i | input | 1 | Permit write-and-invalidate |
| pcix_mode_i | input | 1 | 1: PCI-X bus mode, 0: PCI mode |
| burst_cap_i | input | LEN_W | Maximum burst length in bytes (0 acts as 1) |
| desc_valid_o | output | 1 | Descriptor is presented |
| desc_ready_i | input | 1 | Bus master accepts the descriptor |
| desc_cmd_o | output | 4 | Bus command code |
| desc_addr_o | output | ADDR_W | Burst start address |
| desc_len_o | output | LEN_W | Burst length in bytes |
| burst_done_i | input | 1 | The accepted burst has completed |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse at job end |

## Verification
The bench builds the block with a 12-bit address, a 10-bit byte count and a 9-bit cap. With those widths, a full cross of line sizes (valid, non-power-of-two and oversized), start offsets on and just off a boundary, counts from zero to several hundred bytes, caps from below one line to above the count, and all three mode combinations all fit in one short run. Every buffer is walked to the end, so head, body and tail bursts all occur in each configuration. The small cap width also reaches the cap-of-zero case and caps that cut invalidate bursts mid-buffer.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    localparam logic [3:0] CMD_MW  = 4'b0111;
    localparam logic [3:0] CMD_MWI = 4'b1111;
    localparam logic [3:0] CMD_MWB = 4'b1111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } wrb_state_e;

    typedef struct packed {
        logic [7:0] line_words;
        logic       inval_en;
        logic       pcix;
    } wrb_cfg_t;

    function automatic logic line_words_ok(input logic [7:0] w);
        return (w == 8'd1) || (w == 8'd2) || (w == 8'd4) ||
               (w == 8'd8) || (w == 8'd16) || (w == 8'd32);
    endfunction

    // Byte mask of the offset inside a line; zero when the size is unusable.
    function automatic logic [7:0] line_mask(input logic [7:0] w);
        logic [7:0] bytes;
        bytes = {w[5:0], 2'b00};
        return line_words_ok(w) ? (bytes - 8'd1) : 8'd0;
    endfunction

    function automatic logic inval_allowed(input wrb_cfg_t c);
        return c.inval_en && !c.pcix && line_words_ok(c.line_words);
    endfunction

endpackage

// File: rtl/wrb_sizer.sv
module wrb_sizer
    import wrb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  rem_i,
    input  logic [LEN_W-1:0]  cap_i,
    input  wrb_cfg_t          cfg_i,
    output logic [3:0]        cmd_o,
    output logic [LEN_W-1:0]  len_o
);

    logic [7:0]       mask;
    logic [7:0]       offs;
    logic [8:0]       to_bound;
    logic [CNT_W-1:0] cap_e;
    logic [CNT_W-1:0] keep;
    logic [CNT_W-1:0] whole;
    logic [CNT_W-1:0] cap_lines;
    logic [CNT_W-1:0] plain;
    logic [CNT_W-1:0] bound;
    logic [CNT_W-1:0] head;
    logic [CNT_W-1:0] inval;
    logic [CNT_W-1:0] len_full;
    logic             use_inval;

    always_comb begin
        use_inval = inval_allowed(cfg_i);
        mask      = line_mask(cfg_i.line_words);
        offs      = addr_i[7:0] & mask;
        to_bound  = {1'b0, mask} + 9'd1 - {1'b0, offs};
        cap_e     = (cap_i == '0) ? CNT_W'(1) : CNT_W'(cap_i);
        keep      = ~CNT_W'(mask);
        whole     = rem_i & keep;
        cap_lines = cap_e & keep;
        plain     = (rem_i < cap_e) ? rem_i : cap_e;
        bound     = CNT_W'(to_bound);
        head      = (plain < bound) ? plain : bound;
        inval     = (whole < cap_lines) ? whole : cap_lines;

        if (!use_inval) begin
            cmd_o    = cfg_i.pcix ? CMD_MWB : CMD_MW;
            len_full = plain;
        end else if (offs != 8'd0) begin
            cmd_o    = CMD_MW;
            len_full = head;
        end else if ((whole == '0) || (cap_lines == '0)) begin
            cmd_o    = CMD_MW;
            len_full = plain;
        end else begin
            cmd_o    = CMD_MWI;
            len_full = inval;
        end
        len_o = len_full[LEN_W-1:0];
    end

endmodule

// File: rtl/wrb_cursor.sv
module wrb_cursor
    import wrb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [LEN_W-1:0]  cap_i,
    input  wrb_cfg_t          cfg_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  rem_o,
    output logic [LEN_W-1:0]  cap_o,
    output wrb_cfg_t          cfg_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LEN_W-1:0]  cap_q;
    wrb_cfg_t          cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
            cap_q  <= '0;
            cfg_q  <= '0;
        end else if (load_i) begin
            addr_q <= start_addr_i;
            rem_q  <= count_i;
            cap_q  <= cap_i;
            cfg_q  <= cfg_i;
        end else if (adv_i) begin
            addr_q <= addr_q + ADDR_W'(len_i);
            rem_q  <= rem_q - CNT_W'(len_i);
        end
    end

    assign addr_o = addr_q;
    assign rem_o  = rem_q;
    assign cap_o  = cap_q;
    assign cfg_o  = cfg_q;
    assign last_o = (rem_q == CNT_W'(len_i));

    // R10: an advance never consumes more than what remains, nor nothing
    p_adv_within_r10: assert property (@(posedge clk) disable iff (rst)
        adv_i |-> (CNT_W'(len_i) <= rem_q) && (len_i != '0));

endmodule

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
    import wrb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic count_zero_i,
    input  logic desc_ready_i,
    input  logic burst_done_i,
    input  logic last_i,
    output logic load_o,
    output logic adv_o,
    output logic desc_valid_o,
    output logic busy_o,
    output logic done_o
);

    wrb_state_e state_q, state_d;
    logic       done_q, done_d;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        load_o  = 1'b0;
        adv_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_zero_i) begin
                        done_d = 1'b1;
                    end else begin
                        load_o  = 1'b1;
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (desc_ready_i) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (burst_done_i) begin
                    adv_o = 1'b1;
                    if (last_i) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign desc_valid_o = (state_q == ST_ISSUE);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;

    // R2: an empty job completes at once without presenting anything
    p_zero_job_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && count_zero_i) |=> (done_o && !desc_valid_o));

    // R9: an accepted descriptor is withdrawn on the following cycle
    p_drop_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && desc_ready_i) |=> !desc_valid_o);

    // R9: completion before acceptance leaves the descriptor presented
    p_early_done_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && !desc_ready_i && burst_done_i) |=> desc_valid_o);

    // R11: a start during a job never reloads the cursor
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !load_o);

endmodule

// File: rtl/dma_wr_burst_planner.sv
module dma_wr_burst_planner
    import wrb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic [7:0]        line_words_i,
    input  logic              inval_en_i,
    input  logic              pcix_mode_i,
    input  logic [LEN_W-1:0]  burst_cap_i,
    output logic              desc_valid_o,
    input  logic              desc_ready_i,
    output logic [3:0]        desc_cmd_o,
    output logic [ADDR_W-1:0] desc_addr_o,
    output logic [LEN_W-1:0]  desc_len_o,
    input  logic              burst_done_i,
    output logic              busy_o,
    output logic              done_o
);

    localparam int MIN_CNT_W = (LEN_W > 9) ? LEN_W : 9;

    wrb_cfg_t          cfg_in;
    wrb_cfg_t          cfg_cur;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_rem;
    logic [LEN_W-1:0]  cur_cap;
    logic [LEN_W-1:0]  plan_len;
    logic [3:0]        plan_cmd;
    logic              load, adv, last;

    generate
        if (CNT_W < MIN_CNT_W || ADDR_W < 8) begin : g_bad_widths
            initial $error("CNT_W must be at least max(LEN_W,9), ADDR_W at least 8");
        end
    endgenerate

    assign cfg_in = '{line_words: line_words_i, inval_en: inval_en_i, pcix: pcix_mode_i};

    wrb_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .count_zero_i (byte_count_i == '0),
        .desc_ready_i (desc_ready_i),
        .burst_done_i (burst_done_i),
        .last_i       (last),
        .load_o       (load),
        .adv_o        (adv),
        .desc_valid_o (desc_valid_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    wrb_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_cursor (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .adv_i        (adv),
        .start_addr_i (start_addr_i),
        .count_i      (byte_count_i),
        .cap_i        (burst_cap_i),
        .cfg_i        (cfg_in),
        .len_i        (plan_len),
        .addr_o       (cur_addr),
        .rem_o        (cur_rem),
        .cap_o        (cur_cap),
        .cfg_o        (cfg_cur),
        .last_o       (last)
    );

    wrb_sizer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_sizer (
        .addr_i (cur_addr),
        .rem_i  (cur_rem),
        .cap_i  (cur_cap),
        .cfg_i  (cfg_cur),
        .cmd_o  (plan_cmd),
        .len_o  (plan_len)
    );

    assign desc_cmd_o  = plan_cmd;
    assign desc_addr_o = cur_addr;
    assign desc_len_o  = plan_len;

    // R9: descriptor contents stay put while waiting for acceptance
    p_hold_fields_r9: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && !desc_ready_i) |=>
            (desc_valid_o && $stable({desc_cmd_o, desc_addr_o, desc_len_o})));

    // R8: a presented burst is never longer than the latched cap
    p_len_capped_r8: assert property (@(posedge clk) disable iff (rst)
        desc_valid_o |-> (desc_len_o != '0) &&
            ((cur_cap == '0) ? (desc_len_o == LEN_W'(1)) : (desc_len_o <= cur_cap)));

    // R6: invalidate bursts in PCI mode start on a line and cover whole lines
    p_inval_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && !cfg_cur.pcix && cfg_cur.inval_en &&
         line_words_ok(cfg_cur.line_words) && desc_cmd_o == CMD_MWI) |->
            (((desc_addr_o[7:0] | desc_len_o[7:0]) & line_mask(cfg_cur.line_words)) == 8'd0));

    // R3: without invalidate permission PCI mode only uses the plain write code
    p_plain_only_r3: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && !cfg_cur.pcix && !cfg_cur.inval_en) |-> (desc_cmd_o == CMD_MW));

    // R4: PCI-X mode uses the block-write code throughout
    p_pcix_block_r4: assert property (@(posedge clk) disable iff (rst)
        (desc_valid_o && cfg_cur.pcix) |-> (desc_cmd_o == CMD_MWB));

endmodule

// File: tb/dma_wr_burst_planner_test.sv
module dma_wr_burst_planner_test;

    localparam int AW = 12;
    localparam int CW = 10;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [AW-1:0] start_addr_i;
    logic [CW-1:0] byte_count_i;
    logic [7:0]    line_words_i;
    logic          inval_en_i;
    logic          pcix_mode_i;
    logic [LW-1:0] burst_cap_i;
    logic          desc_valid_o;
    logic          desc_ready_i;
    logic [3:0]    desc_cmd_o;
    logic [AW-1:0] desc_addr_o;
    logic [LW-1:0] desc_len_o;
    logic          burst_done_i;
    logic          busy_o;
    logic          done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_wr_burst_planner #(.ADDR_W(AW), .CNT_W(CW), .LEN_W(LW)) uut (
        .clk (clk), .rst (rst), .start_i (start_i),
        .start_addr_i (start_addr_i), .byte_count_i (byte_count_i),
        .line_words_i (line_words_i), .inval_en_i (inval_en_i),
        .pcix_mode_i (pcix_mode_i), .burst_cap_i (burst_cap_i),
        .desc_valid_o (desc_valid_o), .desc_ready_i (desc_ready_i),
        .desc_cmd_o (desc_cmd_o), .desc_addr_o (desc_addr_o),
        .desc_len_o (desc_len_o), .burst_done_i (burst_done_i),
        .busy_o (busy_o), .done_o (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected burst from the requirements, computed arithmetically
    task automatic model(input int a, input int rem, input int words, input int mwi,
                         input int pcix, input int cap, output int cmd, output int len,
                         output string tag);
        int line, cap_e, off, whole, cl, plain;
        bit ok;
        ok    = (mwi != 0) && (pcix == 0) &&
                (words == 1 || words == 2 || words == 4 || words == 8 ||
                 words == 16 || words == 32);
        line  = words * 4;
        cap_e = (cap == 0) ? 1 : cap;
        plain = (rem < cap_e) ? rem : cap_e;
        if (!ok) begin
            cmd = (pcix != 0) ? 15 : 7;
            len = plain;
            tag = (pcix != 0) ? "R4" : "R3";
        end else begin
            off = a % line;
            if (off != 0) begin
                cmd = 7;
                len = (plain < line - off) ? plain : line - off;
                tag = "R5";
            end else begin
                whole = (rem / line) * line;
                cl    = (cap_e / line) * line;
                if (whole == 0) begin
                    cmd = 7; len = plain; tag = "R7";
                end else if (cl == 0) begin
                    cmd = 7; len = plain; tag = "R8";
                end else begin
                    cmd = 15; len = (whole < cl) ? whole : cl; tag = "R6";
                end
            end
        end
    endtask

    task automatic run_case(input int addr, input int count, input int words,
                            input int mwi, input int pcix, input int cap);
        int a, rem, cmd, len, cap_e;
        string tag;
        a = addr; rem = count;
        cap_e = (cap == 0) ? 1 : cap;
        @(negedge clk);
        start_addr_i = AW'(addr);
        byte_count_i = CW'(count);
        line_words_i = 8'(words);
        inval_en_i   = mwi[0];
        pcix_mode_i  = pcix[0];
        burst_cap_i  = LW'(cap);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (count == 0) begin
            check("R2 done after empty start", int'(done_o), 1);
            check("R2 no descriptor", int'(desc_valid_o), 0);
            @(negedge clk);
            check("R2 done single cycle", int'(done_o), 0);
            return;
        end
        for (int k = 0; rem > 0 && k < 700; k++) begin
            if (!desc_valid_o) begin
                check("R10 descriptor presented", 0, 1);
                return;
            end
            model(a, rem, words, mwi, pcix, cap, cmd, len, tag);
            check({tag, " cmd"}, int'(desc_cmd_o), cmd);
            check({tag, " len"}, int'(desc_len_o), len);
            check("R10 addr", int'(desc_addr_o), a);
            if (int'(desc_len_o) > cap_e) check("R8 len within cap", int'(desc_len_o), cap_e);
            if (k % 3 == 1) begin
                burst_done_i = 1'b1;
                @(negedge clk);
                burst_done_i = 1'b0;
                check("R9 held valid", int'(desc_valid_o), 1);
                check("R9 held len", int'(desc_len_o), len);
                check("R9 held addr", int'(desc_addr_o), a);
            end
            desc_ready_i = 1'b1;
            @(negedge clk);
            desc_ready_i = 1'b0;
            check("R9 valid low after accept", int'(desc_valid_o), 0);
            if (k % 4 == 2) begin
                start_i      = 1'b1;
                start_addr_i = AW'(a + 7);
                byte_count_i = CW'(5);
                @(negedge clk);
                start_i = 1'b0;
                check("R11 still waiting", int'(desc_valid_o), 0);
            end
            burst_done_i = 1'b1;
            @(negedge clk);
            burst_done_i = 1'b0;
            a   = a + len;
            rem = rem - len;
        end
        check("R10 done pulse", int'(done_o), 1);
        check("R10 idle at end", int'(busy_o), 0);
        @(negedge clk);
        check("R10 done single cycle", int'(done_o), 0);
    endtask

    int words_set[7] = '{0, 1, 3, 4, 16, 32, 64};
    int offs_set[3]  = '{0, 2, 126};
    int count_set[5] = '{0, 3, 64, 100, 300};
    int cap_set[3]   = '{5, 64, 511};

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; start_addr_i = '0; byte_count_i = '0;
        line_words_i = '0; inval_en_i = 1'b0; pcix_mode_i = 1'b0;
        burst_cap_i = '0; desc_ready_i = 1'b0; burst_done_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(desc_valid_o), 0);
        check("R1 busy in reset", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(desc_valid_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 done after reset", int'(done_o), 0);

        // R8: zero cap acts as one byte, aligned bursts fall back to plain writes
        run_case(12'h100, 20, 4, 1, 0, 0);

        foreach (words_set[w]) begin
            foreach (offs_set[o]) begin
                foreach (count_set[c]) begin
                    foreach (cap_set[p]) begin
                        for (int m = 0; m < 3; m++) begin
                            run_case(12'h100 + offs_set[o], count_set[c], words_set[w],
                                     (m == 0) ? 0 : 1, (m == 2) ? 1 : 0, cap_set[p]);
                        end
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule